// File: doc/BRIEF.md
# Redundant-Input Decimal Compound Adder

This block turns a p-digit decimal operand held in carry-save form into two ordinary BCD words in the same pass. Each digit position carries a 4-bit BCD sum digit together with a single pending carry bit. The block returns the operand's value and that value plus one unit in the least significant digit. A rounding stage downstream picks one of the two, so it never needs a second carry-propagating addition.

Each digit cell works out two candidate result digits: one for "no carry arrives" and one for "a carry arrives". It also derives a digit generate and a digit propagate straight from the redundant pair. A parallel prefix network turns these into two carry vectors, one with no carry injected at the bottom and one with a carry injected there. Each vector then selects candidates to form the corresponding result. A separate one-digit incrementer serves the guard position. Its carry is reported only as a flag and never enters the main word. All outputs are registered.

Top module: `csd_compound_add`

## Requirements
- R1: While `rst_n` is low, and at the first sampling after it, all outputs (`res_p0`, `res_p1`, `guard_out`, `guard_cy`) are zero.
- R2: Results appear one clock after the inputs are presented: the output register captures on each rising edge the value computed from the inputs present just before that edge.
- R3: Digit i of the operand is `sum_in[4i+3:4i]` (BCD, 0 to 9, bit 3 the most significant bit) plus `cry_in[i]`, weighted by 10^i, with digit 0 the least significant. `res_p0` is the BCD encoding of the operand value modulo 10^16, with the same digit layout.
- R4: `res_p1` is the BCD encoding of (operand value + 1) modulo 10^16.
- R5: A position with sum digit 9 and carry bit 1 (digit value ten) emits a carry into the next position in both results, and itself reads 0 in `res_p0`.
- R6: Positions whose digit value is nine pass an incoming carry through. A run of such positions resolves in a single pass, and all-nines with no carry bits gives `res_p1` equal to zero.
- R7: A carry out of the most significant digit is discarded in both results.
- R8: `guard_out` is (`guard_in` + 1) mod 10, and `guard_cy` is 1 exactly when `guard_in` is 9.
- R9: `guard_in` has no effect on `res_p0` or `res_p1`.
- R10: Every output digit is a valid BCD code, 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| sum_in | input | 64 | Sum digits of the carry-save operand, 16 BCD digits, digit 0 at bits 3:0 |
| cry_in | input | 16 | Carry bits of the operand, bit i belongs to digit i |
| guard_in | input | 4 | Guard digit to be incremented (BCD) |
| res_p0 | output | 64 | Registered operand value, 16 BCD digits |
| res_p1 | output | 64 | Registered operand value plus one, 16 BCD digits |
| guard_out | output | 4 | Registered incremented guard digit |
| guard_cy | output | 1 | Registered carry out of the guard incrementer |

## Verification
The assertions take for granted that every sum digit on `sum_in` is a legal BCD code, 0 to 9. One assertion watches that assumption, because the generate and propagate terms read only the two outer bits of a digit and lose their meaning for codes 10 to 15. The stimulus respects this by building every operand digit as a value reduced modulo ten, and by writing edge cases such as all nines, all tens and nine-runs digit by digit. The carry bits and the guard digit range freely, since every combination of them is legal.

// File: rtl/csd_pkg.sv
`timescale 1ns/1ps
package csd_pkg;
    localparam int unsigned BCD_W = 4;
    typedef logic [BCD_W-1:0] bcd_t;
    localparam bcd_t BCD_NINE = 4'd9;
    localparam bcd_t BCD_ZERO = 4'd0;

    function automatic bcd_t bcd_wrap(input logic [BCD_W:0] raw);
        logic [BCD_W:0] adj;
        adj = (raw >= 5'd10) ? (raw - 5'd10) : raw;
        return adj[BCD_W-1:0];
    endfunction
endpackage

// File: rtl/csd_digit_cell.sv
`timescale 1ns/1ps
module csd_digit_cell
    import csd_pkg::*;
(
    input  bcd_t s_dig,
    input  logic c_bit,
    output bcd_t cand_lo,
    output bcd_t cand_hi,
    output logic dgen,
    output logic dprop
);
    logic [BCD_W:0] base_val;
    logic [BCD_W:0] base_inc;

    always_comb begin
        base_val = {1'b0, s_dig} + {{BCD_W{1'b0}}, c_bit};
        base_inc = base_val + 5'd1;
        cand_lo  = bcd_wrap(base_val);
        cand_hi  = bcd_wrap(base_inc);
        // value ten: carries out regardless of the incoming carry
        dgen     = s_dig[BCD_W-1] & s_dig[0] & c_bit;
        // value nine or ten: forwards an incoming carry
        dprop    = s_dig[BCD_W-1] & (s_dig[0] | c_bit);
    end
endmodule

// File: rtl/csd_prefix_net.sv
`timescale 1ns/1ps
module csd_prefix_net #(
    parameter int unsigned N = 16
) (
    input  logic [N-1:0] gen_in,
    input  logic [N-1:0] prop_in,
    output logic [N-1:0] carry_z,
    output logic [N-1:0] carry_o,
    output logic         msd_cout_z,
    output logic         msd_cout_o
);
    localparam int unsigned LVL = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0] grp_g [0:LVL];
    logic [N-1:0] grp_p [0:LVL];

    always_comb begin
        grp_g[0] = gen_in;
        grp_p[0] = prop_in;
        for (int k = 0; k < LVL; k++) begin
            for (int i = 0; i < N; i++) begin
                if (i >= (1 << k)) begin
                    grp_g[k+1][i] = grp_g[k][i] | (grp_p[k][i] & grp_g[k][i - (1 << k)]);
                    grp_p[k+1][i] = grp_p[k][i] & grp_p[k][i - (1 << k)];
                end else begin
                    grp_g[k+1][i] = grp_g[k][i];
                    grp_p[k+1][i] = grp_p[k][i];
                end
            end
        end
    end

    always_comb begin
        carry_z[0] = 1'b0;
        carry_o[0] = 1'b1;
        for (int i = 1; i < N; i++) begin
            carry_z[i] = grp_g[LVL][i-1];
            carry_o[i] = grp_g[LVL][i-1] | grp_p[LVL][i-1];
        end
        msd_cout_z = grp_g[LVL][N-1];
        msd_cout_o = grp_g[LVL][N-1] | grp_p[LVL][N-1];
    end
endmodule

// File: rtl/csd_guard_inc.sv
`timescale 1ns/1ps
module csd_guard_inc
    import csd_pkg::*;
(
    input  bcd_t gd_in,
    output bcd_t gd_next,
    output logic gd_cy
);
    always_comb begin
        gd_cy   = (gd_in == BCD_NINE);
        gd_next = bcd_wrap({1'b0, gd_in} + 5'd1);
    end
endmodule

// File: rtl/csd_compound_add.sv
`timescale 1ns/1ps
module csd_compound_add
    import csd_pkg::*;
#(
    parameter int unsigned DIGITS = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DIGITS*4-1:0]     sum_in,
    input  logic [DIGITS-1:0]       cry_in,
    input  logic [3:0]              guard_in,
    output logic [DIGITS*4-1:0]     res_p0,
    output logic [DIGITS*4-1:0]     res_p1,
    output logic [3:0]              guard_out,
    output logic                    guard_cy
);
    localparam int unsigned WORD_W = DIGITS * BCD_W;

    logic [DIGITS-1:0] dig_gen;
    logic [DIGITS-1:0] dig_prop;
    logic [DIGITS-1:0] car_z;
    logic [DIGITS-1:0] car_o;
    logic              top_cz;
    logic              top_co;
    logic [WORD_W-1:0] cand_lo_w;
    logic [WORD_W-1:0] cand_hi_w;
    logic [WORD_W-1:0] nxt_p0;
    logic [WORD_W-1:0] nxt_p1;
    bcd_t              nxt_guard;
    logic              nxt_gcy;
    logic              primed;

    for (genvar d = 0; d < DIGITS; d++) begin : g_cell
        csd_digit_cell u_cell (
            .s_dig  (sum_in[d*BCD_W +: BCD_W]),
            .c_bit  (cry_in[d]),
            .cand_lo(cand_lo_w[d*BCD_W +: BCD_W]),
            .cand_hi(cand_hi_w[d*BCD_W +: BCD_W]),
            .dgen   (dig_gen[d]),
            .dprop  (dig_prop[d])
        );
        assign nxt_p0[d*BCD_W +: BCD_W] = car_z[d] ? cand_hi_w[d*BCD_W +: BCD_W]
                                                   : cand_lo_w[d*BCD_W +: BCD_W];
        assign nxt_p1[d*BCD_W +: BCD_W] = car_o[d] ? cand_hi_w[d*BCD_W +: BCD_W]
                                                   : cand_lo_w[d*BCD_W +: BCD_W];
    end

    csd_prefix_net #(.N(DIGITS)) u_net (
        .gen_in    (dig_gen),
        .prop_in   (dig_prop),
        .carry_z   (car_z),
        .carry_o   (car_o),
        .msd_cout_z(top_cz),
        .msd_cout_o(top_co)
    );

    csd_guard_inc u_gin (
        .gd_in  (guard_in),
        .gd_next(nxt_guard),
        .gd_cy  (nxt_gcy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_p0    <= '0;
            res_p1    <= '0;
            guard_out <= '0;
            guard_cy  <= 1'b0;
            primed    <= 1'b0;
        end else begin
            res_p0    <= nxt_p0;
            res_p1    <= nxt_p1;
            guard_out <= nxt_guard;
            guard_cy  <= nxt_gcy;
            primed    <= 1'b1;
        end
    end

    // input legality: sum digits must be BCD (R3)
    for (genvar d = 0; d < DIGITS; d++) begin : g_inchk
        assert_in_bcd_R3: assert property (@(posedge clk) disable iff (!rst_n)
            sum_in[d*BCD_W +: BCD_W] <= BCD_NINE);
        assert_out_bcd_R10: assert property (@(posedge clk) disable iff (!rst_n)
            primed |-> (res_p0[d*BCD_W +: BCD_W] <= BCD_NINE) &&
                       (res_p1[d*BCD_W +: BCD_W] <= BCD_NINE));
    end

    // a digit that generates must also propagate (R5)
    assert_gen_in_prop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_gen & ~dig_prop) == '0);

    // injecting a carry can only add carries, including at the MSD (R6, R7)
    assert_carry_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((car_z & ~car_o) == '0) && !(top_cz && !top_co));

    // least significant digit of the +1 result follows the +0 result (R4)
    assert_lsd_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> res_p1[BCD_W-1:0] ==
                   ((res_p0[BCD_W-1:0] == BCD_NINE) ? BCD_ZERO : res_p0[BCD_W-1:0] + 4'd1));

    // guard carry only when the guard wraps to zero (R8)
    assert_guard_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        guard_cy |-> guard_out == BCD_ZERO);

    // zero operand presented one cycle earlier yields 0 and 1 (R2)
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(primed) && $past(sum_in) == '0 && $past(cry_in) == '0)
            |-> (res_p0 == '0) && (res_p1 == {{(WORD_W-1){1'b0}}, 1'b1}));
endmodule

// File: tb/sim_csd_compound_add.sv
`timescale 1ns/1ps
module sim_csd_compound_add;
    localparam int DIGITS = 16;
    localparam logic [63:0] MODV = 64'd10000000000000000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [63:0]       sum_in = '0;
    logic [15:0]       cry_in = '0;
    logic [3:0]        guard_in = '0;
    logic [63:0]       res_p0;
    logic [63:0]       res_p1;
    logic [3:0]        guard_out;
    logic              guard_cy;

    int checks = 0;
    int failures = 0;
    logic [31:0] lcg = 32'h1234_5678;

    always #2.5 clk = ~clk;

    csd_compound_add #(.DIGITS(DIGITS)) u0 (
        .clk(clk), .rst_n(rst_n), .sum_in(sum_in), .cry_in(cry_in),
        .guard_in(guard_in), .res_p0(res_p0), .res_p1(res_p1),
        .guard_out(guard_out), .guard_cy(guard_cy)
    );

    function automatic logic [63:0] op_value(input logic [63:0] s, input logic [15:0] c);
        logic [63:0] v = '0;
        for (int i = DIGITS - 1; i >= 0; i--)
            v = v * 64'd10 + {60'd0, s[i*4 +: 4]} + {63'd0, c[i]};
        return v % MODV;
    endfunction

    function automatic logic [63:0] to_bcd(input logic [63:0] v);
        logic [63:0] r = '0;
        logic [63:0] t = v;
        for (int i = 0; i < DIGITS; i++) begin
            r[i*4 +: 4] = 4'(t % 64'd10);
            t = t / 64'd10;
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, sample at the next falling edge (one capture between)
    task automatic apply_and_check(input string tag, input logic [63:0] s,
                                   input logic [15:0] c, input logic [3:0] g);
        logic [63:0] v;
        @(negedge clk);
        sum_in = s; cry_in = c; guard_in = g;
        @(negedge clk);
        v = op_value(s, c);
        chk({tag, " R3 p0"}, res_p0, to_bcd(v));
        chk({tag, " R4 p1"}, res_p1, to_bcd((v + 64'd1) % MODV));
    endtask

    function automatic logic [63:0] next_digits();
        logic [63:0] r = '0;
        for (int i = 0; i < DIGITS; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            r[i*4 +: 4] = 4'((lcg >> 16) % 32'd10);
        end
        return r;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk("R1 p0 in reset", res_p0, '0);
        chk("R1 p1 in reset", res_p1, '0);
        chk("R1 guard in reset", {60'd0, guard_out}, '0);
        chk("R1 gcy in reset", {63'd0, guard_cy}, '0);
        sum_in = next_digits(); cry_in = 16'hffff; guard_in = 4'd9;
        @(negedge clk);
        chk("R1 p0 still reset", res_p0, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_latency();
        // R2: value appears after exactly one rising edge
        @(negedge clk);
        sum_in = 64'h0000_0000_0000_0042; cry_in = '0; guard_in = '0;
        @(negedge clk);
        sum_in = 64'h0000_0000_0000_0017;
        chk("R2 first value", res_p0, 64'h42);
        @(negedge clk);
        chk("R2 second value", res_p0, 64'h17);
    endtask

    task automatic t_zero();
        apply_and_check("zero", '0, '0, 4'd0);
    endtask

    task automatic t_patterns();
        for (int n = 0; n < 40; n++) begin
            logic [63:0] s = next_digits();
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            apply_and_check("mixed", s, lcg[27:12], 4'(n % 10));
        end
    endtask

    task automatic t_tens();
        // R5: every digit holds ten, so each emits a carry
        apply_and_check("R5 all tens", {16{4'h9}}, 16'hffff, 4'd0);
        chk("R5 all tens p0", res_p0, 64'h1111_1111_1111_1110);
        // R5: single ten at digit 3
        apply_and_check("R5 single ten", 64'h0000_0000_0000_9000, 16'h0008, 4'd0);
        chk("R5 single ten p0", res_p0, 64'h0000_0000_0001_0000);
    endtask

    task automatic t_nines();
        // R6: all nines, no carry bits -> +1 wraps to zero
        apply_and_check("R6 all nines", {16{4'h9}}, 16'h0000, 4'd0);
        chk("R6 all nines p1", res_p1, '0);
        // R6: run of nines made of 8 plus carry, fed by a ten at the bottom
        apply_and_check("R6 eight-carry run", 64'h0000_0888_8888_8889, 16'h07ff, 4'd0);
        chk("R6 run p0", res_p0, 64'h0000_1000_0000_0000);
    endtask

    task automatic t_msd_wrap();
        // R7: ten at the MSD drops its carry
        apply_and_check("R7 msd ten", 64'h9000_0000_0000_0003, 16'h8000, 4'd0);
        chk("R7 msd ten p0", res_p0, 64'h0000_0000_0000_0003);
        chk("R7 msd ten p1", res_p1, 64'h0000_0000_0000_0004);
    endtask

    task automatic t_guard();
        for (int g = 0; g < 10; g++) begin
            @(negedge clk);
            guard_in = 4'(g);
            @(negedge clk);
            chk("R8 guard digit", {60'd0, guard_out}, 64'((g + 1) % 10));
            chk("R8 guard carry", {63'd0, guard_cy}, (g == 9) ? 64'd1 : 64'd0);
        end
    endtask

    task automatic t_guard_isolation();
        // R9: guard at 9 (carry set) leaves the word untouched
        apply_and_check("R9 guard nine", {16{4'h9}}, 16'h0000, 4'd9);
        chk("R9 p0 unchanged", res_p0, {16{4'h9}});
        chk("R9 p1 unchanged", res_p1, '0);
        chk("R9 guard carry present", {63'd0, guard_cy}, 64'd1);
    endtask

    task automatic t_bcd_valid();
        // R10: scan outputs of one dense pattern for legal digits
        apply_and_check("R10 dense", 64'h9898_9898_9898_9898, 16'haaaa, 4'd5);
        for (int i = 0; i < DIGITS; i++) begin
            chk("R10 p0 digit", {60'd0, res_p0[i*4 +: 4]} <= 64'd9 ? 64'd1 : 64'd0, 64'd1);
            chk("R10 p1 digit", {60'd0, res_p1[i*4 +: 4]} <= 64'd9 ? 64'd1 : 64'd0, 64'd1);
        end
    endtask

    bit done = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency();
        t_zero();
        t_tens();
        t_nines();
        t_msd_wrap();
        t_patterns();
        t_guard();
        t_guard_isolation();
        t_bcd_valid();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule